// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps calendar time from a 32.768 kHz clock enable that arrives in the fabric clock domain. A divider turns that enable into a one-second tick. The tick steps a chain of seconds, minutes, hours and day-number counters. The day number is 15 bits wide and wraps around.

Beside the time chain there are three more functions:
- a one-second countdown timer that signals when it runs past zero;
- an alarm on the time of day that ignores the day number;
- an alarm that also needs the day number to match.

Every event lands in a sticky flag. Software clears a flag by writing a 1 to its bit. A per-flag interrupt mask drives the interrupt output, and a second mask drives the wakeup output. For fast testing, the divider can be bypassed so that each enable counts as a full second.

Software writes the time, the alarm and the countdown value through one write port. The port has a two-bit target select.

Top module: `caltick_rtc`

## Requirements
- R1: After a synchronous reset the outputs are all zero: cur_time, sw_count, evt_flags, irq and wake. The countdown timer is stopped and the alarm register holds zero.
- R2: With pre_bypass low, the time advances by one second on every 32768th cycle in which clk32k_en is high. Writing the time restarts this divide phase, so 32767 enables after a time write leave the time unchanged.
- R3: With pre_bypass high, every cycle in which clk32k_en is high advances the time by one second. The new value appears on cur_time after the next clock edge.
- R4: cur_time is packed as day[31:17], hour[16:12], minute[11:6] and second[5:0]. Seconds and minutes count 0 to 59 and hours count 0 to 23, each carrying into the next field. The day number counts 0 to 32767 and wraps from 32767 to 0.
- R5: Flag bit 0 sets on every second. Bit 1 sets when the seconds wrap to 0. Bit 2 sets when the minutes and seconds both wrap to 0. Bit 3 sets when the time goes from 23:59:59 to 00:00:00.
- R6: Flag bit 5 sets when the time produced by a second tick has the same hour, minute and second as the alarm register, whatever the day. Writing the time never sets it.
- R7: Flag bit 6 sets only when the time produced by a second tick matches the alarm register in day, hour, minute and second.
- R8: Writing N to the countdown timer loads it and starts it. The count drops by one on each second. On the second that finds the count at 0, flag bit 4 sets and the timer stops at 0. After that it raises no further flag until it is written again.
- R9: Flags are sticky. A 1 in evt_clr clears only the bit it covers. A flag that is set and cleared in the same cycle stays set.
- R10: irq is high exactly when some flag is set whose bit in evt_en is 1. evt_en has no effect on whether flags set.
- R11: wake is high exactly when some flag is set whose bit in wake_en is 1.
- R12: wr_sel codes: 0 writes the time, 1 writes the alarm (same packing as cur_time), 2 writes the countdown from wr_data[15:0], and 3 writes nothing. A write in the same cycle as a second tick wins over the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| clk32k_en | input | 1 | One-cycle enable at 32.768 kHz |
| pre_bypass | input | 1 | Treat every enable as one second |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 time, 1 alarm, 2 countdown, 3 none |
| wr_data | input | 32 | Write value |
| evt_en | input | 7 | Interrupt mask per flag |
| wake_en | input | 7 | Wakeup mask per flag |
| evt_clr | input | 7 | Write-one-to-clear per flag |
| cur_time | output | 32 | Current day and time |
| sw_count | output | 16 | Countdown value |
| evt_flags | output | 7 | Sticky event flags |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
The hardest states to reach are the cascaded rollovers: the hour carry, the midnight carry and the 15-bit day wrap. With the divider active, reaching them would take an enormous number of enables.

The stimulus bypasses the divider and writes start times just before each boundary. It then steps one second at a time and compares every step against a time computed from a running count of total seconds. It clears all flags in the same cycle as each tick, so each reading shows only the events of that one second.

The divider itself is checked once, by holding the enable high through one full divide period.

// File: rtl/caltick_pkg.sv
package caltick_pkg;

    localparam int DAY_W  = 15;
    localparam int HR_W   = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;
    localparam int NUM_EV = 7;

    localparam int EV_SEC   = 0;
    localparam int EV_MIN   = 1;
    localparam int EV_HOUR  = 2;
    localparam int EV_DAY   = 3;
    localparam int EV_SW    = 4;
    localparam int EV_DAILY = 5;
    localparam int EV_DATED = 6;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } rtc_time_t;

    localparam int TIME_W = $bits(rtc_time_t);

    typedef enum logic [1:0] {
        SEL_TIME  = 2'd0,
        SEL_ALARM = 2'd1,
        SEL_SW    = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    function automatic logic same_tod(rtc_time_t a, rtc_time_t b);
        return (a.hr == b.hr) && (a.min == b.min) && (a.sec == b.sec);
    endfunction

endpackage

// File: rtl/caltick_prescale.sv
module caltick_prescale #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bypass,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (bypass || (cnt_q == LAST));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (en && !bypass) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: with the divider active, two ticks are never back to back
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !bypass && !restart) |=> !(tick && !bypass));

endmodule

// File: rtl/caltick_counters.sv
module caltick_counters
    import caltick_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      ld,
    input  rtc_time_t ld_val,
    output rtc_time_t q,
    output rtc_time_t nxt,
    output logic [3:0] roll
);
    logic c_sec, c_min, c_hr;

    always_comb begin
        c_sec = (q.sec == SEC_W'(59));
        c_min = c_sec && (q.min == MIN_W'(59));
        c_hr  = c_min && (q.hr == HR_W'(23));
        nxt     = q;
        nxt.sec = c_sec ? '0 : q.sec + 1'b1;
        if (c_sec) nxt.min = (q.min == MIN_W'(59)) ? '0 : q.min + 1'b1;
        if (c_min) nxt.hr  = (q.hr == HR_W'(23)) ? '0 : q.hr + 1'b1;
        if (c_hr)  nxt.day = q.day + 1'b1;
    end

    assign roll = {c_hr, c_min, c_sec, 1'b1} & {4{tick && !ld}};

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (ld)   q <= ld_val;
        else if (tick) q <= nxt;
    end

    // R4: seconds wrap to zero after 59
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && q.sec == SEC_W'(59)) |=> (q.sec == '0));
    // R4: the last day at 23:59:59 wraps to day zero
    p_day_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && (&q.day) && q.hr == HR_W'(23) && q.min == MIN_W'(59)
         && q.sec == SEC_W'(59)) |=> (q.day == '0 && q.hr == '0));

endmodule

// File: rtl/caltick_stopwatch.sv
module caltick_stopwatch #(
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            ld,
    input  logic [SW_W-1:0] ld_val,
    output logic [SW_W-1:0] count,
    output logic            uf
);
    logic run_q;

    assign uf = tick && !ld && run_q && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run_q <= 1'b0;
        end else if (ld) begin
            count <= ld_val;
            run_q <= 1'b1;
        end else if (tick && run_q) begin
            if (count == '0) run_q <= 1'b0;
            else             count <= count - 1'b1;
        end
    end

    // R8: a running nonzero count drops by exactly one per second
    p_sw_dec_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld && run_q && count != '0) |=> (count == $past(count) - 1'b1));
    // R8: the underflow stops the timer at zero
    p_sw_stop_r8: assert property (@(posedge clk) disable iff (rst)
        uf |=> (!run_q && count == '0));

endmodule

// File: rtl/caltick_rtc.sv
module caltick_rtc
    import caltick_pkg::*;
#(
    parameter int PRE_DIV = 32768,
    parameter int SW_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk32k_en,
    input  logic              pre_bypass,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [TIME_W-1:0] wr_data,
    input  logic [NUM_EV-1:0] evt_en,
    input  logic [NUM_EV-1:0] wake_en,
    input  logic [NUM_EV-1:0] evt_clr,
    output logic [TIME_W-1:0] cur_time,
    output logic [SW_W-1:0]   sw_count,
    output logic [NUM_EV-1:0] evt_flags,
    output logic              irq,
    output logic              wake
);
    wr_sel_e     sel;
    logic        ld_time, ld_alarm, ld_sw, tick, uf;
    logic [3:0]  roll;
    rtc_time_t   now_t, nxt_t, alarm_q;
    logic [NUM_EV-1:0] set_v, flag_q;

    assign sel      = wr_sel_e'(wr_sel);
    assign ld_time  = wr_en && (sel == SEL_TIME);
    assign ld_alarm = wr_en && (sel == SEL_ALARM);
    assign ld_sw    = wr_en && (sel == SEL_SW);

    caltick_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .en(clk32k_en), .bypass(pre_bypass),
        .restart(ld_time), .tick(tick)
    );

    caltick_counters u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .ld(ld_time),
        .ld_val(rtc_time_t'(wr_data)), .q(now_t), .nxt(nxt_t), .roll(roll)
    );

    caltick_stopwatch #(.SW_W(SW_W)) u_sw (
        .clk(clk), .rst(rst), .tick(tick), .ld(ld_sw),
        .ld_val(wr_data[SW_W-1:0]), .count(sw_count), .uf(uf)
    );

    always_ff @(posedge clk) begin
        if (rst)           alarm_q <= '0;
        else if (ld_alarm) alarm_q <= rtc_time_t'(wr_data);
    end

    always_comb begin
        set_v           = '0;
        set_v[EV_SEC]   = roll[0];
        set_v[EV_MIN]   = roll[1];
        set_v[EV_HOUR]  = roll[2];
        set_v[EV_DAY]   = roll[3];
        set_v[EV_SW]    = uf;
        set_v[EV_DAILY] = tick && !ld_time && same_tod(nxt_t, alarm_q);
        set_v[EV_DATED] = set_v[EV_DAILY] && (nxt_t.day == alarm_q.day);
    end

    for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= set_v[i] | (flag_q[i] & ~evt_clr[i]);
        end
        // R9: a set flag with no clear stays set
        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !evt_clr[i]) |=> flag_q[i]);
    end

    assign cur_time  = now_t;
    assign evt_flags = flag_q;
    assign irq       = |(flag_q & evt_en);
    assign wake      = |(flag_q & wake_en);

    // R6: the daily alarm flag only rises after a second tick
    p_alarm_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[EV_DAILY]) |-> $past(tick));
    // R7: a dated match is always also a daily match
    p_dated_needs_daily_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[EV_DATED]) |-> flag_q[EV_DAILY]);
    // R10: no flags, no interrupt
    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_q == '0) |-> !irq);

endmodule

// File: tb/caltick_rtc_test.sv
`timescale 1ns/1ps
module caltick_rtc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk32k_en = 1'b0;
    logic        pre_bypass = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic [6:0]  evt_en = 7'h7f;
    logic [6:0]  wake_en = 7'h7f;
    logic [6:0]  evt_clr = '0;
    logic [31:0] cur_time;
    logic [15:0] sw_count;
    logic [6:0]  evt_flags;
    logic        irq, wake;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    caltick_rtc uut (
        .clk(clk), .rst(rst), .clk32k_en(clk32k_en), .pre_bypass(pre_bypass),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .evt_en(evt_en),
        .wake_en(wake_en), .evt_clr(evt_clr), .cur_time(cur_time),
        .sw_count(sw_count), .evt_flags(evt_flags), .irq(irq), .wake(wake)
    );

    localparam longint DAY_S  = 86400;
    localparam longint SPAN_S = 32768 * 86400;

    function automatic logic [31:0] pack_s(longint s);
        longint t = s % SPAN_S;
        logic [31:0] w;
        w[31:17] = 15'(t / DAY_S);
        w[16:12] = 5'((t / 3600) % 24);
        w[11:6]  = 6'((t / 60) % 60);
        w[5:0]   = 6'(t % 60);
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic clear_all();
        evt_clr = 7'h7f;
        @(negedge clk);
        evt_clr = '0;
    endtask

    // one second with all flags cleared in the same cycle (set wins)
    task automatic sec_fresh();
        clk32k_en = 1'b1; evt_clr = 7'h7f;
        @(negedge clk);
        clk32k_en = 1'b0; evt_clr = '0;
    endtask

    task automatic sweep(longint start, longint alarm_s, int n);
        longint s = start;
        longint atod = alarm_s % DAY_S;
        wr(2'd1, pack_s(alarm_s));
        wr(2'd0, pack_s(start));
        clear_all();
        for (int k = 0; k < n; k++) begin
            logic [6:0] ef;
            sec_fresh();
            s = (s + 1) % SPAN_S;
            chk("R3/R4 time step", cur_time, pack_s(s));
            ef = '0;
            ef[0] = 1'b1;
            ef[1] = (s % 60) == 0;
            ef[2] = (s % 3600) == 0;
            ef[3] = (s % DAY_S) == 0;
            ef[5] = (s % DAY_S) == atod;
            ef[6] = s == alarm_s;
            chk("R5/R6/R7 flags", 32'(evt_flags), 32'(ef));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 time", cur_time, 0);
        chk("R1 flags", 32'(evt_flags), 0);
        chk("R1 sw", 32'(sw_count), 0);
        chk("R1 irq/wake", {30'd0, irq, wake}, 0);

        // R4/R5/R6/R7 sweeps in bypass
        sweep(5 * DAY_S, 5 * DAY_S + 1800, 3700);
        sweep(32767 * DAY_S + 23 * 3600 + 58 * 60, 30, 200);
        sweep(32767 * DAY_S + 23 * 3600 + 59 * 60, 3 * DAY_S + 23 * 3600 + 59 * 60 + 10, 30);

        // R6: writing the time equal to the alarm sets nothing
        wr(2'd1, pack_s(DAY_S + 3723));
        clear_all();
        wr(2'd0, pack_s(DAY_S + 3723));
        chk("R6 load no alarm", 32'(evt_flags), 0);

        // R8 countdown
        wr(2'd2, 32'd5);
        chk("R8 loaded", 32'(sw_count), 5);
        for (int k = 1; k <= 5; k++) begin
            sec_fresh();
            chk("R8 count", 32'(sw_count), 32'(5 - k));
            chk("R8 no underflow", 32'(evt_flags[4]), 0);
        end
        sec_fresh();
        chk("R8 underflow flag", 32'(evt_flags[4]), 1);
        chk("R8 stays zero", 32'(sw_count), 0);
        sec_fresh();
        chk("R8 stopped no flag", 32'(evt_flags[4]), 0);

        // R12 write priority and no-op code
        clk32k_en = 1'b1;
        wr(2'd0, pack_s(777));
        clk32k_en = 1'b0;
        chk("R12 time write wins", cur_time, pack_s(777));
        clk32k_en = 1'b1;
        wr(2'd2, 32'd9);
        clk32k_en = 1'b0;
        chk("R12 sw write wins", 32'(sw_count), 9);
        wr(2'd3, 32'h0000_1234);
        chk("R12 code 3 time", cur_time, pack_s(778));
        chk("R12 code 3 sw", 32'(sw_count), 9);

        // R2 divider
        pre_bypass = 1'b0;
        wr(2'd1, pack_s(3 * DAY_S + 500));
        clk32k_en = 1'b1;
        repeat (1000) @(negedge clk);
        clk32k_en = 1'b0;
        wr(2'd0, 32'd0);
        clk32k_en = 1'b1;
        repeat (32767) @(negedge clk);
        clk32k_en = 1'b0;
        chk("R2 restart after write", cur_time, 0);
        clear_all();
        clk32k_en = 1'b1;
        @(negedge clk);
        clk32k_en = 1'b0;
        chk("R2 one second", cur_time, pack_s(1));
        chk("R5 second flag", 32'(evt_flags), 1);

        // R10/R11 masks
        evt_en = '0; wake_en = '0;
        @(negedge clk);
        chk("R10 masked irq", 32'(irq), 0);
        chk("R11 masked wake", 32'(wake), 0);
        chk("R10 flag kept", 32'(evt_flags), 1);
        evt_en = 7'h01; wake_en = 7'h01;
        @(negedge clk);
        chk("R10 irq", 32'(irq), 1);
        chk("R11 wake", 32'(wake), 1);
        evt_en = 7'h7e;
        @(negedge clk);
        chk("R10 other bits", 32'(irq), 0);
        evt_en = 7'h7f;
        // R9 clear only the covered bit
        evt_clr = 7'h02;
        @(negedge clk);
        evt_clr = '0;
        chk("R9 other clear", 32'(evt_flags), 1);
        evt_clr = 7'h01;
        @(negedge clk);
        evt_clr = '0;
        chk("R9 w1c", 32'(evt_flags), 0);
        chk("R10 irq drops", 32'(irq), 0);
        chk("R11 wake drops", 32'(wake), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule